// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets clocked on-chip logic use an external asynchronous static RAM of 131,072 bytes, which takes a 17-bit address. A client presents one request at a time: a direction flag, an address and, for stores, a byte. The block latches the request and drives the memory's chip-select, write-strobe and read-enable pins, all active low, through a fixed sequence of phases. It then raises a one-cycle completion pulse. On a load, the fetched byte is presented alongside that pulse.

Every phase length is a whole number of clock cycles. Each length is derived when the design is elaborated, from the clock period and the memory's minimum timing figures in picoseconds. Each figure is rounded up, and no phase is shorter than one cycle. The byte lane is split into an outgoing value, a drive-enable and an incoming value, so that a tri-state pad outside the block can join them. The block never drives the lane while the memory may still be driving it. For that reason, a store issued at any time after a load first passes through an idle gap.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, chip-select, write-strobe and read-enable are all high, the data drive-enable is 0, the done pulse is 0 and ready is 1.
- R2: A load first spends one cycle with chip-select low and both write-strobe and read-enable high. It then holds chip-select low, read-enable low and write-strobe high for the read-wait length.
- R3: The incoming byte is captured on the edge that ends the read-wait. In the following single cycle, done is 1 and the captured byte is on the read-data output, with chip-select and read-enable already back high. The cycle after that is idle.
- R4: A store has three parts. The first is one set-up cycle with chip-select low, write-strobe high and the drive-enable on. The second is the strobe phase with write-strobe low. The third is one release cycle with write-strobe high, chip-select still low, the drive-enable on and done at 1. Read-enable stays high during the whole store.
- R5: Whenever chip-select is low, the memory address equals the address latched at acceptance. Whenever the drive-enable is on, the outgoing byte equals the latched store byte.
- R6: A store accepted at any time after the most recent load, with no store between them, is preceded by a gap with all three strobes high and the drive-enable off. The gap lasts for the turnaround length. A store after a store, and a load after anything, gets no gap.
- R7: Ready is 1 exactly in idle cycles, and ready drops in the cycle after acceptance. A request presented while ready is 0 is ignored: the pins, the latched address and the latched data do not change.
- R8: The drive-enable is never on while read-enable is low, and write-strobe and read-enable are never low together.
- R9: Each phase length equals the ceiling of the time figure divided by the clock period, with a minimum of 1. The read-wait covers the 8000 ps access time. The turnaround covers the 3500 ps bus release. The strobe length is the largest of three values: the 5500 ps pulse width, the 4000 ps data set-up time less one cycle, and the 8000 ps write cycle less two cycles. At a 4000 ps clock this gives a read-wait of 2 cycles, a strobe of 2 cycles and a turnaround of 1 cycle.
- R10: A byte stored at an address is returned by a later load of that address, including at the lowest address 0x00000 and the highest address 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to store |
| req_ready | output | 1 | Block idle, request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Loaded byte, valid with done |
| sram_addr | output | 17 | Memory address pins |
| sram_cs_n | output | 1 | Chip-select, active low |
| sram_wr_n | output | 1 | Write-strobe, active low |
| sram_rd_n | output | 1 | Read-enable, active low |
| sram_dq_out | output | 8 | Byte for the pad to drive |
| sram_dq_oe | output | 1 | Pad drive-enable |
| sram_dq_in | input | 8 | Byte seen on the pad |

## Verification
The bench attaches a behavioural memory to the pins and drives several kinds of traffic. Back-to-back loads show that no gap is inserted. A store directly after a load, and a store several loads later, show that the gap is inserted. Back-to-back stores show that the gap is skipped. Traffic that holds a conflicting request high during a busy operation shows whether the latched address and byte can be disturbed. Store-then-load pairs at both address extremes, and a long mixed stream, tell a byte that really travelled through the pins apart from the memory's default pattern.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_SETUP,
      ST_RD_WAIT,
      ST_RD_CAPTURE,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RELEASE,
      ST_TURN
   } sram_state_e;

   // Registered pin image: strobes are active low.
   typedef struct packed {
      logic cs_n;
      logic wr_n;
      logic rd_n;
      logic dq_oe;
      logic done;
   } pin_ctl_t;

   localparam pin_ctl_t PINS_QUIET = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, dq_oe: 1'b0, done: 1'b0};

   // Whole clocks covering a time, never below one.
   function automatic int cycles_for(input int t_ps, input int clk_ps);
      int c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      m = (m > c) ? m : c;
      return (m < 1) ? 1 : m;
   endfunction

   function automatic pin_ctl_t pins_for_state(input sram_state_e s);
      pin_ctl_t p;
      p = PINS_QUIET;
      case (s)
         ST_RD_SETUP:   p.cs_n = 1'b0;
         ST_RD_WAIT:    begin p.cs_n = 1'b0; p.rd_n = 1'b0; end
         ST_RD_CAPTURE: p.done = 1'b1;
         ST_WR_SETUP:   begin p.cs_n = 1'b0; p.dq_oe = 1'b1; end
         ST_WR_PULSE:   begin p.cs_n = 1'b0; p.wr_n = 1'b0; p.dq_oe = 1'b1; end
         ST_WR_RELEASE: begin p.cs_n = 1'b0; p.dq_oe = 1'b1; p.done = 1'b1; end
         default:       p = PINS_QUIET;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int MAX_CNT = 2,
   parameter int CW      = $clog2(MAX_CNT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   generate
      if (MAX_CNT < 1) begin : g_bad_cnt
         $error("sram_phase_timer: MAX_CNT must be at least 1");
      end

      if (MAX_CNT == 1) begin : g_single
         // Every timed phase is one cycle: no counter needed.
         logic unused_timer;
         assign unused_timer = ^{clk, rst_n, load, load_val};
         assign expired = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (load)
               cnt_q <= load_val - CW'(1);
            else if (cnt_q != '0)
               cnt_q <= cnt_q - CW'(1);
         end
         assign expired = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int RD_WAIT_CYC  = 2,
   parameter int WR_PULSE_CYC = 2,
   parameter int TURN_CYC     = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   output sram_state_e state_q,
   output sram_state_e state_d,
   output logic        accept,
   output logic        capture
);

   localparam int MAX_CNT = max3(RD_WAIT_CYC, WR_PULSE_CYC, TURN_CYC);
   localparam int CW      = $clog2(MAX_CNT + 1);

   logic          timer_load;
   logic [CW-1:0] timer_val;
   logic          expired;
   logic          last_rd_q;

   sram_phase_timer #(.MAX_CNT(MAX_CNT), .CW(CW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val (timer_val),
      .expired  (expired)
   );

   assign accept  = (state_q == ST_IDLE) && req_valid;
   assign capture = (state_q == ST_RD_WAIT) && expired;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (!req_write)     state_d = ST_RD_SETUP;
               else if (last_rd_q) state_d = ST_TURN;
               else                state_d = ST_WR_SETUP;
            end
         end
         ST_TURN:       if (expired) state_d = ST_WR_SETUP;
         ST_RD_SETUP:   state_d = ST_RD_WAIT;
         ST_RD_WAIT:    if (expired) state_d = ST_RD_CAPTURE;
         ST_RD_CAPTURE: state_d = ST_IDLE;
         ST_WR_SETUP:   state_d = ST_WR_PULSE;
         ST_WR_PULSE:   if (expired) state_d = ST_WR_RELEASE;
         ST_WR_RELEASE: state_d = ST_IDLE;
         default:       state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      timer_load = 1'b0;
      timer_val  = CW'(1);
      if (state_d != state_q) begin
         case (state_d)
            ST_RD_WAIT:  begin timer_load = 1'b1; timer_val = CW'(RD_WAIT_CYC);  end
            ST_WR_PULSE: begin timer_load = 1'b1; timer_val = CW'(WR_PULSE_CYC); end
            ST_TURN:     begin timer_load = 1'b1; timer_val = CW'(TURN_CYC);     end
            default:     timer_load = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         last_rd_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_RD_CAPTURE)
            last_rd_q <= 1'b1;
         else if (state_q == ST_WR_RELEASE)
            last_rd_q <= 1'b0;
      end
   end

endmodule

// File: rtl/sram_pin_stage.sv
module sram_pin_stage
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sram_state_e       state_d,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] sram_dq_in,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs_n,
   output logic              sram_wr_n,
   output logic              sram_rd_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata
);

   pin_ctl_t          ctl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   // Pins follow the state being entered, so they change on the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= PINS_QUIET;
      else
         ctl_q <= pins_for_state(state_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (capture)
         rdata_q <= sram_dq_in;
   end

   assign sram_addr   = addr_q;
   assign sram_cs_n   = ctl_q.cs_n;
   assign sram_wr_n   = ctl_q.wr_n;
   assign sram_rd_n   = ctl_q.rd_n;
   assign sram_dq_oe  = ctl_q.dq_oe;
   assign sram_dq_out = wdata_q;
   assign rsp_done    = ctl_q.done;
   assign rsp_rdata   = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W          = 17,
   parameter int DATA_W          = 8,
   parameter int CLK_PERIOD_PS   = 4000,
   parameter int T_ACCESS_PS     = 8000,
   parameter int T_WR_PULSE_PS   = 5500,
   parameter int T_WR_SETUP_PS   = 4000,
   parameter int T_WR_CYCLE_PS   = 8000,
   parameter int T_BUS_RELEASE_PS = 3500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs_n,
   output logic              sram_wr_n,
   output logic              sram_rd_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);

   localparam int RD_WAIT_CYC  = cycles_for(T_ACCESS_PS, CLK_PERIOD_PS);
   localparam int TURN_CYC     = cycles_for(T_BUS_RELEASE_PS, CLK_PERIOD_PS);
   // Data is driven one set-up cycle before the strobe; release adds one more.
   localparam int WR_PULSE_CYC = max3(cycles_for(T_WR_PULSE_PS, CLK_PERIOD_PS),
                                      cycles_for(T_WR_SETUP_PS, CLK_PERIOD_PS) - 1,
                                      cycles_for(T_WR_CYCLE_PS, CLK_PERIOD_PS) - 2);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_async_ctrl: address and data widths must be positive");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_clk
         $error("sram_async_ctrl: CLK_PERIOD_PS must be positive");
      end
      if ((WR_PULSE_CYC + 2) * CLK_PERIOD_PS < T_WR_CYCLE_PS) begin : g_bad_wcycle
         $error("sram_async_ctrl: store sequence shorter than the write cycle");
      end
      if ((RD_WAIT_CYC * CLK_PERIOD_PS) < T_ACCESS_PS) begin : g_bad_rwait
         $error("sram_async_ctrl: read wait shorter than access time");
      end
   endgenerate

   sram_state_e state_q;
   sram_state_e state_d;
   logic        accept;
   logic        capture;

   sram_ctrl_fsm #(
      .RD_WAIT_CYC  (RD_WAIT_CYC),
      .WR_PULSE_CYC (WR_PULSE_CYC),
      .TURN_CYC     (TURN_CYC)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .state_q   (state_q),
      .state_d   (state_d),
      .accept    (accept),
      .capture   (capture)
   );

   sram_pin_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_d     (state_d),
      .accept      (accept),
      .capture     (capture),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .sram_dq_in  (sram_dq_in),
      .sram_addr   (sram_addr),
      .sram_cs_n   (sram_cs_n),
      .sram_wr_n   (sram_wr_n),
      .sram_rd_n   (sram_rd_n),
      .sram_dq_out (sram_dq_out),
      .sram_dq_oe  (sram_dq_oe),
      .rsp_done    (rsp_done),
      .rsp_rdata   (rsp_rdata)
   );

   assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_done,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_cs_n,
   input logic              sram_wr_n,
   input logic              sram_rd_n,
   input logic [DATA_W-1:0] sram_dq_out,
   input logic              sram_dq_oe
);

   AST_DRIVE_VS_READ: assert property (@(posedge clk) disable iff (!rst_n) !(sram_dq_oe && !sram_rd_n)); // R8
   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!sram_wr_n && !sram_rd_n)); // R8
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr)); // R5
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out)); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done); // R3
   AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (sram_cs_n && sram_wr_n && sram_rd_n && !sram_dq_oe)); // R7
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready); // R7
   AST_STROBE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !sram_wr_n |-> (!sram_cs_n && sram_dq_oe)); // R4

endmodule

bind sram_async_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rsp_done    (rsp_done),
   .sram_addr   (sram_addr),
   .sram_cs_n   (sram_cs_n),
   .sram_wr_n   (sram_wr_n),
   .sram_rd_n   (sram_rd_n),
   .sram_dq_out (sram_dq_out),
   .sram_dq_oe  (sram_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

   localparam int CLK_PS = 4000;

   function automatic int ceil_cyc(input int t);
      int c;
      c = (t + CLK_PS - 1) / CLK_PS;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int strobe_len();
      int m;
      m = ceil_cyc(5500);
      if (ceil_cyc(4000) - 1 > m) m = ceil_cyc(4000) - 1;
      if (ceil_cyc(8000) - 2 > m) m = ceil_cyc(8000) - 2;
      return (m < 1) ? 1 : m;
   endfunction

   // Expected pin image {cs_n, wr_n, rd_n, dq_oe, done}
   localparam logic [4:0] P_IDLE  = 5'b11100;
   localparam logic [4:0] P_RSET  = 5'b01100;
   localparam logic [4:0] P_RWAIT = 5'b01000;
   localparam logic [4:0] P_RCAP  = 5'b11101;
   localparam logic [4:0] P_WSET  = 5'b01110;
   localparam logic [4:0] P_WPUL  = 5'b00110;
   localparam logic [4:0] P_WREL  = 5'b01111;
   localparam logic [4:0] P_TURN  = 5'b11100;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [16:0] req_addr;
   logic [7:0]  req_wdata;
   logic        req_ready, rsp_done;
   logic [7:0]  rsp_rdata;
   logic [16:0] sram_addr;
   logic        sram_cs_n, sram_wr_n, sram_rd_n, sram_dq_oe;
   logic [7:0]  sram_dq_out;
   logic [7:0]  sram_dq_in;

   always #2 clk = ~clk;

   sram_async_ctrl i_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
      .sram_cs_n(sram_cs_n), .sram_wr_n(sram_wr_n), .sram_rd_n(sram_rd_n),
      .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
   );

   // Behavioural memory on the pins
   function automatic logic [7:0] init_val(input logic [16:0] a);
      return a[7:0] ^ a[15:8] ^ {7'd0, a[16]};
   endfunction

   logic [7:0] dev_mem [int];
   always @(posedge sram_wr_n) begin
      if (sram_cs_n === 1'b0 && sram_dq_oe === 1'b1)
         dev_mem[int'(sram_addr)] = sram_dq_out;
   end
   always @(sram_cs_n or sram_rd_n or sram_wr_n or sram_addr) begin
      if (sram_cs_n === 1'b0 && sram_rd_n === 1'b0 && sram_wr_n === 1'b1)
         sram_dq_in = dev_mem.exists(int'(sram_addr)) ? dev_mem[int'(sram_addr)] : init_val(sram_addr);
      else
         sram_dq_in = 8'hA5;
   end

   // Reference model state
   logic [4:0]  exp_q [$];
   string       tag_q [$];
   logic [7:0]  ref_mem [int];
   bit          last_rd = 1'b0;
   logic [16:0] cur_addr = '0;
   logic [7:0]  cur_data = '0;
   logic [7:0]  exp_rd = '0;
   bit          cur_wr = 1'b0;
   string       cur_rtag = "R3";
   int          n_tests = 0;
   int          n_fail = 0;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_cycle();
      logic [4:0] e;
      string      t;
      bit         was_empty;
      was_empty = (exp_q.size() == 0);
      if (was_empty) begin
         e = P_IDLE; t = "R7";
      end else begin
         e = exp_q.pop_front(); t = tag_q.pop_front();
      end
      chk(t, "pins", {27'd0, sram_cs_n, sram_wr_n, sram_rd_n, sram_dq_oe, rsp_done}, {27'd0, e});
      chk("R7", "ready", {31'd0, req_ready}, {31'd0, was_empty});
      if (!sram_cs_n) chk("R5", "addr", {15'd0, sram_addr}, {15'd0, cur_addr});
      if (sram_dq_oe) chk("R5", "dout", {24'd0, sram_dq_out}, {24'd0, cur_data});
      chk("R8", "drive_vs_read", {31'd0, sram_dq_oe & ~sram_rd_n}, 32'd0);
      chk("R8", "strobe_overlap", {31'd0, ~sram_wr_n & ~sram_rd_n}, 32'd0);
      if (!was_empty && e[0] && !cur_wr)
         chk(cur_rtag, "rdata", {24'd0, rsp_rdata}, {24'd0, exp_rd});
   endtask

   task automatic cycle();
      @(negedge clk);
      check_cycle();
   endtask

   task automatic push(input logic [4:0] p, input string t);
      exp_q.push_back(p);
      tag_q.push_back(t);
   endtask

   task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                        input bit noisy, input string rtag);
      cycle();
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      cur_addr = a; cur_wr = wr; cur_rtag = rtag;
      if (wr) begin
         cur_data = d;
         if (last_rd) for (int k = 0; k < ceil_cyc(3500); k++) push(P_TURN, "R6");
         push(P_WSET, "R4");
         for (int k = 0; k < strobe_len(); k++) push(P_WPUL, "R9");
         push(P_WREL, "R4");
         ref_mem[int'(a)] = d;
         last_rd = 1'b0;
      end else begin
         push(P_RSET, "R2");
         for (int k = 0; k < ceil_cyc(8000); k++) push(P_RWAIT, "R9");
         push(P_RCAP, "R3");
         exp_rd = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
         last_rd = 1'b1;
      end
      while (exp_q.size() > 0) begin
         cycle();
         if (noisy && exp_q.size() > 0) begin
            req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
         end else begin
            req_valid = 1'b0;
         end
      end
   endtask

   task automatic run_all();
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R1", "reset_pins", {27'd0, sram_cs_n, sram_wr_n, sram_rd_n, sram_dq_oe, rsp_done}, {27'd0, P_IDLE});
         chk("R1", "reset_ready", {31'd0, req_ready}, 32'd1);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "post_reset_pins", {27'd0, sram_cs_n, sram_wr_n, sram_rd_n, sram_dq_oe, rsp_done}, {27'd0, P_IDLE});
      // Load of unwritten location, then back-to-back load (no gap)
      do_op(1'b0, 17'h00010, 8'h00, 1'b0, "R3");
      do_op(1'b0, 17'h00011, 8'h00, 1'b0, "R3");
      // Store right after a load: gap expected (R6)
      do_op(1'b1, 17'h00010, 8'h3C, 1'b0, "R6");
      // Store after store: no gap
      do_op(1'b1, 17'h1FFFF, 8'hC3, 1'b0, "R6");
      do_op(1'b1, 17'h00000, 8'h5A, 1'b0, "R10");
      do_op(1'b0, 17'h1FFFF, 8'h00, 1'b0, "R10");
      do_op(1'b0, 17'h00000, 8'h00, 1'b0, "R10");
      do_op(1'b0, 17'h00010, 8'h00, 1'b0, "R10");
      // Idle cycles after a load, then a store: gap still expected
      for (int i = 0; i < 4; i++) cycle();
      do_op(1'b1, 17'h0ABCD, 8'h81, 1'b1, "R7");
      // Conflicting requests held during busy operations
      do_op(1'b0, 17'h0ABCD, 8'h00, 1'b1, "R7");
      do_op(1'b1, 17'h12345, 8'h7E, 1'b1, "R7");
      do_op(1'b0, 17'h12345, 8'h00, 1'b0, "R10");
      // Mixed stream
      for (int i = 0; i < 40; i++) begin
         logic [16:0] a;
         a = 17'((i * 7919 + 13) % 64) | 17'h10000;
         do_op((i % 3) != 0, a, 8'((i * 37) ^ 8'h96), (i % 5) == 0, "R10");
      end
      cycle();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule